// File: doc/BRIEF.md
# Logic Analyzer Capture Sequencer

This block runs one acquisition of a 16-channel logic analyzer. Software sets it up through a bank of byte-wide registers. The settings are the sample-rate divisor, the number of samples to take before the trigger, the total number of samples and a channel enable mask. A command write then starts the run. From a fast base clock the block derives a sample strobe. It takes the pre-trigger samples, waits for the single trigger input, and then keeps sampling until the total count is reached.

Samples are run-length compressed into repetition packets. Each packet holds one 16-bit sample and a repeat count. A packet closes when an enabled channel changes or when its repeat count is full. Each closed packet leaves the block as one write strobe together with a sequential write position, which stands in for the memory. A 16-bit run-state code shows the current phase. After the run, three 32-bit counters describe what was stored: the number of packets, the number of packets before the trigger, and the write position.

Top module: `la_capture_seq`

## Requirements
- R1: A write of 0x03 to register 0x00 starts a capture in any state, clears the sample, packet and write-position counters, and leaves the idle state. A write of any value other than 0x03 or 0x00 to register 0x00 has no effect.
- R2: The run-state code reads low byte at read address 0x00 and high byte at 0x01. The codes are: 0x85E0 idle, 0x85E2 pre-trigger sampling, 0x85EA waiting for trigger, 0x85EE post-trigger sampling, 0x85ED done. A capture passes through them in that order.
- R3: With a pre-trigger count of zero, a start goes directly to waiting for the trigger.
- R4: The 16-bit divisor is written as low byte at 0x1D and high byte at 0x1E. While sampling, one sample is taken every D clocks for a divisor D of 2 or more, and on every clock for a divisor of 0 or 1.
- R5: The pre-trigger count is a little-endian 32-bit value at 0x15–0x18. Pre-trigger sampling lasts exactly that many samples. The total count is a little-endian 32-bit value at 0x10–0x13. It counts all samples, pre-trigger ones included, and the run becomes done once that many have been taken.
- R6: The trigger input moves the sequencer from waiting to post-trigger sampling. In every other state it has no effect, and without it the waiting state is held.
- R7: The 16-bit channel enable mask is written as low byte at 0x20 and high byte at 0x21. A sample that differs from the open packet's sample on an enabled channel closes that packet and opens a new one. Differences on disabled channels are ignored.
- R8: The stored word is {repeat count, sample}, with the repeat count in the upper REP_W bits. It is the number of samples after the first that the packet held. When it is at its maximum, the next sample opens a new packet.
- R9: Every closed packet produces one cycle of wr_valid, with wr_pos counting 0, 1, 2, … from the start. The packet still open at the end of the run is written one cycle after the done state is entered.
- R10: Read addresses 0x10–0x1B return three little-endian 32-bit counters. These are the packet count at 0x10, the packet count at the moment of the trigger at 0x14, and the number of words written at 0x18.
- R11: A write of 0x00 to register 0x00 returns any state to idle and keeps the counters readable at 0x10–0x1B unchanged.
- R12: Every other read address, including the write-only setup registers, reads 0xFF.
- R13: Bit 0 of register 0x03 selects streaming (1) or store-to-memory (0) and is presented on stream_mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register write address |
| reg_wdata | input | 8 | Register write data |
| rd_addr | input | 7 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| smp_in | input | CH_W | Channel inputs |
| trig_in | input | 1 | Trigger event |
| wr_valid | output | 1 | One packet word is being written |
| wr_word | output | CH_W+REP_W | Packet word {repeat count, sample} |
| wr_pos | output | 32 | Write position of wr_word |
| stream_mode | output | 1 | Selected capture mode |

## Verification
The packet logic is driven with three input patterns. A constant input must collapse into a single packet, or into saturating chunks when the repeat counter is small, which exposes repeat-count and saturation errors. An input that changes on every clock must give one packet per sample; run across the trigger, this separates the pre-trigger packet snapshot from the full count. An input that changes only in the upper byte is run twice, once with those channels masked and once with them enabled, which shows whether the mask is applied on the correct channels. The divisor is checked by counting the clocks spent in pre-trigger sampling for divisors 3 and 0, and a 300-sample run checks the little-endian byte order of the counters.

// File: rtl/la_seq_pkg.sv
package la_seq_pkg;
    localparam int CNT_W = 32;
    localparam int CNT_B = CNT_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PRE, ST_WAIT, ST_RUN, ST_DONE
    } seq_state_e;

    localparam logic [6:0] A_CTRL  = 7'h00;
    localparam logic [6:0] A_STATH = 7'h01;
    localparam logic [6:0] A_MODE  = 7'h03;
    localparam logic [6:0] A_TOTAL = 7'h10;
    localparam logic [6:0] A_INFO  = 7'h10;
    localparam logic [6:0] A_PRE   = 7'h15;
    localparam logic [6:0] A_DIV   = 7'h1D;
    localparam logic [6:0] A_MASK  = 7'h20;

    localparam logic [7:0] CMD_GO   = 8'h03;
    localparam logic [7:0] CMD_STOP = 8'h00;

    function automatic logic [15:0] state_code(seq_state_e s);
        case (s)
            ST_PRE:  return 16'h85E2;
            ST_WAIT: return 16'h85EA;
            ST_RUN:  return 16'h85EE;
            ST_DONE: return 16'h85ED;
            default: return 16'h85E0;
        endcase
    endfunction
endpackage

// File: rtl/la_rate_div.sv
module la_rate_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_s;

    div_s             cur_q, nxt_d;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim   = (div <= DIV_W'(1)) ? '0 : div - DIV_W'(1);
        tick  = en && (cur_q.cnt >= lim);
        nxt_d = cur_q;
        if (restart || !en || tick) nxt_d.cnt = '0;
        else                        nxt_d.cnt = cur_q.cnt + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R4
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && lim != '0 && !restart) |=> (!tick || !$stable(div)));
endmodule

// File: rtl/la_packetizer.sv
module la_packetizer #(
    parameter int CH_W  = 16,
    parameter int REP_W = 8,
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  tick,
    input  logic                  flush,
    input  logic [CH_W-1:0]       smp,
    input  logic [CH_W-1:0]       mask,
    output logic                  out_valid,
    output logic [CH_W+REP_W-1:0] out_word,
    output logic [CNT_W-1:0]      out_pos,
    output logic [CNT_W-1:0]      pkt_cnt,
    output logic [CNT_W-1:0]      word_cnt
);
    typedef struct packed {
        logic                  open;
        logic [CH_W-1:0]       cur;
        logic [REP_W-1:0]      rep;
        logic [CNT_W-1:0]      pkt;
        logic [CNT_W-1:0]      pos;
        logic                  vld;
        logic [CH_W+REP_W-1:0] word;
        logic [CNT_W-1:0]      wpos;
    } pk_s;

    pk_s  c_q, n_d;
    logic diff, sat;

    always_comb begin
        diff    = |((smp ^ c_q.cur) & mask);
        sat     = &c_q.rep;
        n_d     = c_q;
        n_d.vld = 1'b0;
        if (clear) begin
            n_d = '0;
        end else if (tick) begin
            if (!c_q.open || diff || sat) begin
                if (c_q.open) begin
                    n_d.vld  = 1'b1;
                    n_d.word = {c_q.rep, c_q.cur};
                    n_d.wpos = c_q.pos;
                    n_d.pos  = c_q.pos + CNT_W'(1);
                end
                n_d.open = 1'b1;
                n_d.cur  = smp;
                n_d.rep  = '0;
                n_d.pkt  = c_q.pkt + CNT_W'(1);
            end else begin
                n_d.rep = c_q.rep + REP_W'(1);
            end
        end else if (flush && c_q.open) begin
            n_d.vld  = 1'b1;
            n_d.word = {c_q.rep, c_q.cur};
            n_d.wpos = c_q.pos;
            n_d.pos  = c_q.pos + CNT_W'(1);
            n_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= n_d;
    end

    assign out_valid = c_q.vld;
    assign out_word  = c_q.word;
    assign out_pos   = c_q.wpos;
    assign pkt_cnt   = c_q.pkt;
    assign word_cnt  = c_q.pos;

    // R9
    emit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(tick || flush));

    // R8
    sat_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear && c_q.open && (&c_q.rep)) |=> (out_valid && out_word[CH_W +: REP_W] == '1));
endmodule

// File: rtl/la_seq_fsm.sv
module la_seq_fsm
    import la_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_halt,
    input  logic             tick,
    input  logic             trig,
    input  logic [CNT_W-1:0] pre_cnt,
    input  logic [CNT_W-1:0] total_cnt,
    output seq_state_e       state,
    output logic             enter_run,
    output logic             flush
);
    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] scnt;
        logic             fl;
    } fsm_s;

    fsm_s             c_q, n_d;
    logic [CNT_W-1:0] inc;

    always_comb begin
        inc       = c_q.scnt + CNT_W'(1);
        n_d       = c_q;
        n_d.fl    = 1'b0;
        enter_run = 1'b0;
        if (cmd_halt) begin
            n_d.st = ST_IDLE;
        end else if (cmd_start) begin
            n_d.scnt = '0;
            n_d.st   = (pre_cnt == '0) ? ST_WAIT : ST_PRE;
        end else begin
            case (c_q.st)
                ST_PRE: if (tick) begin
                    n_d.scnt = inc;
                    if (inc >= pre_cnt) n_d.st = ST_WAIT;
                end
                ST_WAIT: if (trig) begin
                    n_d.st    = ST_RUN;
                    enter_run = 1'b1;
                end
                ST_RUN: if (tick) begin
                    n_d.scnt = inc;
                    if (inc >= total_cnt) begin
                        n_d.st = ST_DONE;
                        n_d.fl = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, scnt: '0, fl: 1'b0};
        else        c_q <= n_d;
    end

    assign state = c_q.st;
    assign flush = c_q.fl;

    // R6
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_WAIT && !trig && !cmd_start && !cmd_halt) |=> c_q.st == ST_WAIT);

    // R2
    run_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_RUN && !cmd_start && !cmd_halt) |=> (c_q.st == ST_RUN || c_q.st == ST_DONE));

    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_DONE && !cmd_start && !cmd_halt) |=> c_q.st == ST_DONE);

    // R11
    halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_halt |=> c_q.st == ST_IDLE);
endmodule

// File: rtl/la_capture_seq.sv
module la_capture_seq
    import la_seq_pkg::*;
#(
    parameter int CH_W  = 16,
    parameter int REP_W = 8,
    parameter int DIV_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [6:0]            reg_addr,
    input  logic [7:0]            reg_wdata,
    input  logic [6:0]            rd_addr,
    output logic [7:0]            rd_data,
    input  logic [CH_W-1:0]       smp_in,
    input  logic                  trig_in,
    output logic                  wr_valid,
    output logic [CH_W+REP_W-1:0] wr_word,
    output logic [CNT_W-1:0]      wr_pos,
    output logic                  stream_mode
);
    localparam int CH_B  = CH_W / 8;
    localparam int DIV_B = DIV_W / 8;
    localparam int INF_B = 3 * CNT_B;

    typedef struct packed {
        logic             mode;
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] pre;
        logic [DIV_W-1:0] div;
        logic [CH_W-1:0]  mask;
        logic [CNT_W-1:0] pre_pkt;
    } regs_s;

    regs_s              r_q, r_d;
    logic               cmd_start, cmd_halt, tick, enter_run, flush, sampling;
    seq_state_e         state;
    logic [CNT_W-1:0]   pkt_cnt, word_cnt;
    logic [8*INF_B-1:0] info;
    logic [15:0]        code;

    assign cmd_start = reg_wr && reg_addr == A_CTRL && reg_wdata == CMD_GO;
    assign cmd_halt  = reg_wr && reg_addr == A_CTRL && reg_wdata == CMD_STOP;
    assign sampling  = state == ST_PRE || state == ST_RUN;

    always_comb begin
        r_d = r_q;
        if (reg_wr) begin
            if (reg_addr == A_MODE) r_d.mode = reg_wdata[0];
            for (int i = 0; i < CNT_B; i++) begin
                if (reg_addr == A_TOTAL + 7'(i)) r_d.total[8*i +: 8] = reg_wdata;
                if (reg_addr == A_PRE + 7'(i))   r_d.pre[8*i +: 8]   = reg_wdata;
            end
            for (int i = 0; i < DIV_B; i++)
                if (reg_addr == A_DIV + 7'(i)) r_d.div[8*i +: 8] = reg_wdata;
            for (int i = 0; i < CH_B; i++)
                if (reg_addr == A_MASK + 7'(i)) r_d.mask[8*i +: 8] = reg_wdata;
        end
        if (cmd_start)      r_d.pre_pkt = '0;
        else if (enter_run) r_d.pre_pkt = pkt_cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    la_rate_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .en(sampling), .restart(cmd_start),
        .div(r_q.div), .tick(tick)
    );

    la_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_halt(cmd_halt),
        .tick(tick), .trig(trig_in), .pre_cnt(r_q.pre), .total_cnt(r_q.total),
        .state(state), .enter_run(enter_run), .flush(flush)
    );

    la_packetizer #(.CH_W(CH_W), .REP_W(REP_W), .CNT_W(CNT_W)) u_pkt (
        .clk(clk), .rst_n(rst_n), .clear(cmd_start), .tick(tick), .flush(flush),
        .smp(smp_in), .mask(r_q.mask), .out_valid(wr_valid), .out_word(wr_word),
        .out_pos(wr_pos), .pkt_cnt(pkt_cnt), .word_cnt(word_cnt)
    );

    always_comb begin
        code = state_code(state);
        info = {word_cnt, r_q.pre_pkt, pkt_cnt};
        if (rd_addr == A_CTRL)       rd_data = code[7:0];
        else if (rd_addr == A_STATH) rd_data = code[15:8];
        else if (rd_addr >= A_INFO && rd_addr < A_INFO + 7'(INF_B))
            rd_data = info[8*int'(rd_addr - A_INFO) +: 8];
        else rd_data = 8'hFF;
    end

    assign stream_mode = r_q.mode;

    // R1
    start_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !cmd_halt) |=> (state == ST_PRE || state == ST_WAIT));

    // R3
    zero_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && r_q.pre == '0) |=> state == ST_WAIT);
endmodule

// File: tb/sim_la_capture_seq.sv
module sim_la_capture_seq;
    localparam int REP_W = 4;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0, trig_in = 1'b0;
    logic [6:0]  reg_addr = '0, rd_addr = '0;
    logic [7:0]  reg_wdata = '0, rd_data;
    logic [15:0] smp_in = '0;
    logic        wr_valid, stream_mode;
    logic [19:0] wr_word;
    logic [31:0] wr_pos;

    int n_chk = 0, n_fail = 0;
    int smode = 0;
    logic [15:0] cyc = '0;
    int vtot = 0, vbase = 0;
    logic [19:0] fw = '0;

    always #4 clk = ~clk;

    la_capture_seq #(.REP_W(REP_W)) u0 (.*);

    always @(negedge clk) begin
        cyc <= cyc + 16'd1;
        case (smode)
            1: smp_in <= cyc;
            2: smp_in <= {cyc[7:0], 8'h00};
            default: smp_in <= 16'h1234;
        endcase
        if (wr_valid) begin
            if (vtot == vbase) fw = wr_word;
            vtot = vtot + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr32(input logic [6:0] a, input logic [31:0] v);
        for (int i = 0; i < 4; i++) wr(a + 7'(i), v[8*i +: 8]);
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic status(output logic [15:0] s);
        logic [7:0] lo, hi;
        rd(7'h00, lo); rd(7'h01, hi); s = {hi, lo};
    endtask

    task automatic rd32(input logic [6:0] a, output logic [31:0] v);
        for (int i = 0; i < 4; i++) begin
            logic [7:0] b;
            rd(a + 7'(i), b); v[8*i +: 8] = b;
        end
    endtask

    task automatic wait_code(input logic [15:0] c, input string req);
        logic [15:0] s;
        for (int i = 0; i < 5000; i++) begin
            status(s);
            if (s == c) break;
            @(negedge clk);
        end
        chk(req, s, c);
    endtask

    task automatic cfg(input int pre, input int tot, input int dv, input logic [15:0] m, input int sm);
        wr32(7'h15, pre); wr32(7'h10, tot);
        wr(7'h1D, dv[7:0]); wr(7'h1E, dv[15:8]);
        wr(7'h20, m[7:0]); wr(7'h21, m[15:8]);
        smode = sm;
    endtask

    task automatic go();
        vbase = vtot;
        wr(7'h00, 8'h03);
    endtask

    task automatic fire();
        @(negedge clk); trig_in = 1'b1;
        @(negedge clk); trig_in = 1'b0;
    endtask

    task automatic capture(input int pre, input int tot, input logic [15:0] m, input int sm);
        cfg(pre, tot, 1, m, sm);
        go();
        wait_code(16'h85EA, "R2 wait");
        fire();
        wait_code(16'h85ED, "R5 done");
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] s; logic [7:0] b;
        status(s); chk("R2 reset idle code", s, 16'h85E0);
        rd(7'h05, b); chk("R12 unmapped FF", b, 8'hFF);
        rd(7'h10, b); chk("R10 reset info", b, 8'h00);
        chk("R13 reset mode", stream_mode, 0);
        chk("R9 no write at reset", wr_valid, 0);
    endtask

    task automatic t_ignore();
        logic [15:0] s;
        wr(7'h00, 8'h01); status(s); chk("R1 other cmd ignored", s, 16'h85E0);
        fire(); status(s); chk("R6 trigger ignored idle", s, 16'h85E0);
    endtask

    task automatic t_const();
        logic [15:0] s; logic [31:0] v;
        cfg(0, 10, 1, 16'hFFFF, 0);
        go(); status(s); chk("R3 zero pre to wait", s, 16'h85EA);
        repeat (5) @(negedge clk);
        status(s); chk("R6 wait holds", s, 16'h85EA);
        fire(); status(s); chk("R2 run code", s, 16'h85EE);
        wait_code(16'h85ED, "R5 done");
        repeat (3) @(negedge clk);
        rd32(7'h10, v); chk("R7 constant one packet", v, 1);
        rd32(7'h18, v); chk("R10 word count", v, 1);
        chk("R9 one strobe", vtot - vbase, 1);
        chk("R8 word repeat", fw, 20'h91234);
    endtask

    task automatic t_sat();
        logic [31:0] v;
        capture(0, 40, 16'hFFFF, 0);
        rd32(7'h10, v); chk("R8 saturation packets", v, 3);
        chk("R8 saturated word", fw, 20'hF1234);
        chk("R9 strobes", vtot - vbase, 3);
    endtask

    task automatic t_distinct();
        logic [31:0] v; logic [15:0] s;
        cfg(5, 10, 1, 16'hFFFF, 1);
        go(); status(s); chk("R2 pre code", s, 16'h85E2);
        wait_code(16'h85EA, "R5 pre ends");
        fire(); wait_code(16'h85ED, "R5 done");
        repeat (3) @(negedge clk);
        rd32(7'h10, v); chk("R7 changing packets", v, 10);
        rd32(7'h14, v); chk("R10 pre-trigger packets", v, 5);
        rd32(7'h18, v); chk("R10 write pos", v, 10);
        chk("R9 strobes", vtot - vbase, 10);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        capture(0, 10, 16'h00FF, 2);
        rd32(7'h10, v); chk("R7 masked channels ignored", v, 1);
        capture(0, 10, 16'hFF00, 2);
        rd32(7'h10, v); chk("R7 enabled channels split", v, 10);
    endtask

    task automatic t_rate(input int dv, input int exp);
        logic [15:0] s; int n = 0;
        cfg(6, 7, dv, 16'hFFFF, 0);
        go();
        for (int i = 0; i < 200; i++) begin
            status(s);
            if (s == 16'h85E2) n++;
            @(negedge clk);
        end
        chk("R4 pre clocks for divisor", n, exp);
        wr(7'h00, 8'h00);
    endtask

    task automatic t_halt();
        logic [15:0] s; logic [31:0] v;
        cfg(5, 10, 1, 16'hFFFF, 1);
        go(); wait_code(16'h85EA, "R2 wait");
        wr(7'h00, 8'h00); status(s); chk("R11 halt idle", s, 16'h85E0);
        rd32(7'h10, v); chk("R11 counters kept", v, 5);
    endtask

    task automatic t_mode();
        logic [7:0] b;
        wr(7'h03, 8'h01); chk("R13 stream", stream_mode, 1);
        rd(7'h03, b); chk("R12 mode not readable", b, 8'hFF);
        wr(7'h03, 8'h00); chk("R13 store", stream_mode, 0);
    endtask

    task automatic t_order();
        logic [7:0] b;
        capture(0, 300, 16'hFFFF, 1);
        rd(7'h10, b); chk("R10 byte0", b, 8'h2C);
        rd(7'h11, b); chk("R10 byte1", b, 8'h01);
        rd(7'h19, b); chk("R10 pos byte1", b, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ignore();
        t_const();
        t_sat();
        t_distinct();
        t_mask();
        t_rate(3, 18);
        t_rate(0, 6);
        t_halt();
        t_mode();
        t_order();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule